// File: doc/BRIEF.md
# Interrupt translation register file

This block is the memory-mapped control front end of an interrupt translation unit. A simple request bus reaches it with 32-bit or 64-bit reads and writes. It holds a set-only control word with an enable bit, a fixed identification word, a read-only capability (type) word, a command queue base, the command queue write and read pointers, and eight table base registers in a 64-byte window. Each request gets a registered response one cycle later, with read data and an error flag.

Once the unit is enabled, the command queue base and the table bases are frozen. Setting the enable bit clears the queue read pointer. On the next cycle a one-cycle pulse tells the downstream geometry decoder to capture the table and queue parameters, which appear on dedicated outputs. The command engine, which is not part of this block, advances the read pointer through a load port. Software cannot write the read pointer.

Top module: `itu_regfile`

## Requirements
- R1: After reset every stored register reads zero, table bases read only their constant fields, and rsp_valid_o, latch_o and en_o are low.
- R2: Accesses with addr_i[1:0] not zero, to an unimplemented offset, 64-bit at an offset other than 0x008, 0x080, 0x088, 0x090 or 0x100+8k, 64-bit with addr_i[2] set, or writes to 0x004, 0x008/0x00C or 0x090/0x094 all get rsp_err_o=1 with zero data and change no state.
- R3: A write to the control word at 0x000 ORs the written value into it. Writing zero clears nothing, so bit 0 (enable, en_o) stays set once set.
- R4: A control write that sets bit 0 while it was clear resets the read pointer to zero at that edge and raises latch_o for exactly the following cycle.
- R5: While enable is set, writes to the queue base (0x080/0x084) and the table bases are dropped with an OK response.
- R6: A permitted write to the low half of the queue base (0x080, 32-bit) or a 64-bit write to it also zeroes the read pointer. A write to the high half (0x084) does not.
- R7: Table base writes store only the writable bits: bits [58:56] and [52:48] are masked off for 32-bit and 64-bit writes alike. Reads return in those fields the per-table type constant and the shared entry-size constant.
- R8: The 64-bit registers (type 0x008, queue base 0x080, write pointer 0x088, read pointer 0x090) read as one 64-bit word or as two 32-bit halves, with addr_i[2] selecting the upper half. 32-bit writes to the queue base and write pointer replace only the addressed half.
- R9: When it is not being cleared, the read pointer loads rptr_i in a cycle with rptr_we_i high. A clear wins over a load.
- R10: Every request gets exactly one response with rsp_valid_o high in the next cycle. Writes return zero data, and 32-bit reads return the word zero-extended.
- R11: Table base k sits at offset 0x100 + 8k, for k from 0 to 7, and is reported on tbl_base_o[64k +: 64].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request valid |
| we_i | input | 1 | Write when high, read when low |
| wide_i | input | 1 | 64-bit access when high, 32-bit when low |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 64 | Write data (low 32 bits used for 32-bit writes) |
| rptr_we_i | input | 1 | Read pointer load from the command engine |
| rptr_i | input | 64 | Read pointer load value |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_err_o | output | 1 | Error response |
| rsp_rdata_o | output | 64 | Read data |
| en_o | output | 1 | Enable bit of the control word |
| latch_o | output | 1 | One-cycle parameter capture pulse |
| cq_base_o | output | 64 | Command queue base |
| wptr_o | output | 64 | Command queue write pointer |
| rptr_o | output | 64 | Command queue read pointer |
| tbl_base_o | output | 512 | Eight table bases including constant fields |

## Verification
Errors in the decoder or the lock show up in the very next response: a wrong error flag, or a read of the locked base that has changed. A lost clear of the read pointer is visible on rptr_o in the cycle after the enabling or low-half write, together with latch_o in that same cycle. Masking errors appear on the first read of a table base, because the constant fields would then carry written bits. A control bit that was wrongly cleared shows on en_o one cycle after the write.

// File: rtl/itu_pkg.sv
package itu_pkg;
  localparam int TBL_N     = 8;
  localparam int TBL_IDX_W = $clog2(TBL_N);

  localparam int OFF_CTRL  = 'h000;
  localparam int OFF_IDENT = 'h004;
  localparam int OFF_TYPE  = 'h008;
  localparam int OFF_CQB   = 'h080;
  localparam int OFF_WPTR  = 'h088;
  localparam int OFF_RPTR  = 'h090;
  localparam int OFF_TBL   = 'h100;

  localparam logic [63:0] TBL_CONST_MASK = (64'h7 << 56) | (64'h1f << 48);
  localparam logic [63:0] TBL_WMASK      = ~TBL_CONST_MASK;

  typedef enum logic [2:0] {
    RS_NONE, RS_CTRL, RS_IDENT, RS_TYPE, RS_CQB, RS_WPTR, RS_RPTR, RS_TBL
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e               sel;
    logic                   hi;
    logic [TBL_IDX_W-1:0]   idx;
    logic                   err;
  } dec_t;
endpackage

// File: rtl/itu_addr_dec.sv
module itu_addr_dec
  import itu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  input  logic              we_i,
  output dec_t              dec_o
);
  localparam int SW = ADDR_W - 3;
  localparam logic [SW-1:0] S_CTRL = SW'(OFF_CTRL >> 3);
  localparam logic [SW-1:0] S_TYPE = SW'(OFF_TYPE >> 3);
  localparam logic [SW-1:0] S_CQB  = SW'(OFF_CQB  >> 3);
  localparam logic [SW-1:0] S_WPTR = SW'(OFF_WPTR >> 3);
  localparam logic [SW-1:0] S_RPTR = SW'(OFF_RPTR >> 3);
  localparam logic [SW-1:0] S_TBL  = SW'(OFF_TBL  >> 3);
  localparam logic [SW-1:0] S_TEND = SW'((OFF_TBL >> 3) + TBL_N);

  logic [SW-1:0] slot;
  logic [SW-1:0] rel;
  logic          ro;

  assign slot = addr_i[ADDR_W-1:3];
  assign rel  = slot - S_TBL;

  always_comb begin
    dec_o     = '0;
    dec_o.hi  = addr_i[2];
    dec_o.idx = rel[TBL_IDX_W-1:0];
    ro        = 1'b0;
    if (slot == S_CTRL) begin
      dec_o.sel = addr_i[2] ? RS_IDENT : RS_CTRL;
      ro        = addr_i[2];
      if (wide_i) dec_o.err = 1'b1;
    end else if (slot == S_TYPE) begin
      dec_o.sel = RS_TYPE;
      ro        = 1'b1;
    end else if (slot == S_CQB) begin
      dec_o.sel = RS_CQB;
    end else if (slot == S_WPTR) begin
      dec_o.sel = RS_WPTR;
    end else if (slot == S_RPTR) begin
      dec_o.sel = RS_RPTR;
      ro        = 1'b1;
    end else if (slot >= S_TBL && slot < S_TEND) begin
      dec_o.sel = RS_TBL;
    end else begin
      dec_o.err = 1'b1;
    end
    if (addr_i[1:0] != 2'b00) dec_o.err = 1'b1;
    if (wide_i && addr_i[2])  dec_o.err = 1'b1;
    if (we_i && ro)           dec_o.err = 1'b1;
    if (dec_o.err)            dec_o.sel = RS_NONE;
  end
endmodule

// File: rtl/itu_tbl_bank.sv
module itu_tbl_bank
  import itu_pkg::*;
#(
  parameter logic [3*TBL_N-1:0] TBL_TYPES = '0,
  parameter logic [4:0]         ENTRY_SZ  = 5'd0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [TBL_IDX_W-1:0]  idx_i,
  input  logic                  hi_i,
  input  logic                  wide_i,
  input  logic [63:0]           wdata_i,
  output logic [TBL_N*64-1:0]   tbl_o
);
  for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
    logic [63:0] q;
    logic [63:0] nxt;
    logic [63:0] cst;

    assign cst = {5'd0, TBL_TYPES[3*g +: 3], 3'd0, ENTRY_SZ, 48'd0};

    always_comb begin
      if (wide_i)    nxt = wdata_i & TBL_WMASK;
      else if (hi_i) nxt = {wdata_i[31:0] & TBL_WMASK[63:32], q[31:0]};
      else           nxt = {q[63:32], wdata_i[31:0] & TBL_WMASK[31:0]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= '0;
      else if (wr_i && idx_i == TBL_IDX_W'(g))  q <= nxt;
    end

    assign tbl_o[64*g +: 64] = q | cst;
  end
endmodule

// File: rtl/itu_cmdq_ctrl.sv
module itu_cmdq_ctrl #(
  parameter int CTRL_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              cqb_wr_i,
  input  logic              wptr_wr_i,
  input  logic              hi_i,
  input  logic              wide_i,
  input  logic [63:0]       wdata_i,
  input  logic              rptr_we_i,
  input  logic [63:0]       rptr_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [63:0]       cqb_o,
  output logic [63:0]       wptr_o,
  output logic [63:0]       rptr_o,
  output logic              latch_o
);
  logic set_en;
  logic rptr_clr;

  assign set_en   = ctrl_wr_i && wdata_i[0] && !ctrl_o[0];
  assign rptr_clr = set_en || (cqb_wr_i && (wide_i || !hi_i));

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] wd,
                                       input logic wide, input logic hi);
    if (wide)    return wd;
    else if (hi) return {wd[31:0], old[31:0]};
    else         return {old[63:32], wd[31:0]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      cqb_o   <= '0;
      wptr_o  <= '0;
      rptr_o  <= '0;
      latch_o <= 1'b0;
    end else begin
      latch_o <= set_en;
      if (ctrl_wr_i) ctrl_o <= ctrl_o | wdata_i[CTRL_W-1:0];
      if (cqb_wr_i)  cqb_o  <= merge(cqb_o, wdata_i, wide_i, hi_i);
      if (wptr_wr_i) wptr_o <= merge(wptr_o, wdata_i, wide_i, hi_i);
      if (rptr_clr)       rptr_o <= '0;
      else if (rptr_we_i) rptr_o <= rptr_i;
    end
  end
endmodule

// File: rtl/itu_regfile.sv
module itu_regfile
  import itu_pkg::*;
#(
  parameter int                 ADDR_W    = 12,
  parameter logic [31:0]        IDENT_VAL = 32'h1a2b_0001,
  parameter logic [63:0]        TYPE_VAL  = 64'h0000_0000_0013_2f01,
  parameter logic [3*TBL_N-1:0] TBL_TYPES = 24'h000021,
  parameter logic [4:0]         ENTRY_SZ  = 5'd7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic                  wide_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [63:0]           wdata_i,
  input  logic                  rptr_we_i,
  input  logic [63:0]           rptr_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_err_o,
  output logic [63:0]           rsp_rdata_o,
  output logic                  en_o,
  output logic                  latch_o,
  output logic [63:0]           cq_base_o,
  output logic [63:0]           wptr_o,
  output logic [63:0]           rptr_o,
  output logic [TBL_N*64-1:0]   tbl_base_o
);
  localparam int CTRL_W = 32;

  dec_t              dec;
  logic              wr_ok;
  logic [CTRL_W-1:0] ctrl;
  logic [63:0]       rd64;
  logic [63:0]       rd;

  itu_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .wide_i (wide_i),
    .we_i   (we_i),
    .dec_o  (dec)
  );

  assign wr_ok = req_i && we_i && !dec.err;

  itu_cmdq_ctrl #(.CTRL_W(CTRL_W)) u_cq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (wr_ok && dec.sel == RS_CTRL),
    .cqb_wr_i  (wr_ok && dec.sel == RS_CQB && !en_o),
    .wptr_wr_i (wr_ok && dec.sel == RS_WPTR),
    .hi_i      (dec.hi),
    .wide_i    (wide_i),
    .wdata_i   (wdata_i),
    .rptr_we_i (rptr_we_i),
    .rptr_i    (rptr_i),
    .ctrl_o    (ctrl),
    .cqb_o     (cq_base_o),
    .wptr_o    (wptr_o),
    .rptr_o    (rptr_o),
    .latch_o   (latch_o)
  );

  assign en_o = ctrl[0];

  itu_tbl_bank #(.TBL_TYPES(TBL_TYPES), .ENTRY_SZ(ENTRY_SZ)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ok && dec.sel == RS_TBL && !en_o),
    .idx_i   (dec.idx),
    .hi_i    (dec.hi),
    .wide_i  (wide_i),
    .wdata_i (wdata_i),
    .tbl_o   (tbl_base_o)
  );

  always_comb begin
    unique case (dec.sel)
      RS_CTRL:  rd64 = {32'd0, ctrl};
      RS_IDENT: rd64 = {32'd0, IDENT_VAL};
      RS_TYPE:  rd64 = TYPE_VAL;
      RS_CQB:   rd64 = cq_base_o;
      RS_WPTR:  rd64 = wptr_o;
      RS_RPTR:  rd64 = rptr_o;
      RS_TBL:   rd64 = tbl_base_o[64*dec.idx +: 64];
      default:  rd64 = '0;
    endcase
    if (we_i || dec.err)                          rd = '0;
    else if (wide_i)                              rd = rd64;
    else if (dec.hi && dec.sel != RS_IDENT)       rd = {32'd0, rd64[63:32]};
    else                                          rd = {32'd0, rd64[31:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_i;
      rsp_err_o   <= req_i && dec.err;
      rsp_rdata_o <= req_i ? rd : '0;
    end
  end
endmodule

// File: rtl/itu_regfile_chk.sv
module itu_regfile_chk
  import itu_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                rsp_valid_o,
  input logic                rsp_err_o,
  input logic [63:0]         rsp_rdata_o,
  input logic                en_o,
  input logic                latch_o,
  input logic [63:0]         cq_base_o,
  input logic [63:0]         rptr_o,
  input logic [TBL_N*64-1:0] tbl_base_o
);
  p_rsp_next_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  p_no_spur_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  p_err_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_rdata_o == 64'd0 && rsp_valid_o));
  p_en_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> en_o);
  p_pulse_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
  p_pulse_state_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> (en_o && rptr_o == 64'd0));
  p_rise_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> latch_o);
  p_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && $past(en_o)) |-> ($stable(cq_base_o) && $stable(tbl_base_o)));
endmodule

bind itu_regfile itu_regfile_chk u_chk (.*);

// File: tb/itu_regfile_test.sv
module itu_regfile_test;
  import itu_pkg::*;

  localparam logic [31:0] IDENT = 32'h1a2b_0001;
  localparam logic [63:0] TYPEV = 64'h0000_0000_0013_2f01;
  localparam logic [23:0] TTYPES = 24'h000021;
  localparam logic [4:0]  ESZ = 5'd7;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0, wide = 0, rpw = 0;
  logic [11:0] addr = 0;
  logic [63:0] wd = 0, rpv = 0;
  logic rsp_valid, rsp_err, en, latch;
  logic [63:0] rdata, cqb, wptr, rptr;
  logic [511:0] tbl;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_ctrl;
  logic [63:0] m_cqb, m_wptr, m_rptr;
  logic [63:0] m_tbl [8];

  always #5 clk = ~clk;

  itu_regfile uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wd), .rptr_we_i(rpw), .rptr_i(rpv),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rdata),
    .en_o(en), .latch_o(latch), .cq_base_o(cqb), .wptr_o(wptr),
    .rptr_o(rptr), .tbl_base_o(tbl)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] tcst(int k);
    return {5'd0, TTYPES[3*k +: 3], 3'd0, ESZ, 48'd0};
  endfunction

  function automatic bit exp_err(logic [11:0] a, bit w, bit wr);
    int s = int'(a >> 3);
    if (a[1:0] != 0) return 1;
    if (w && a[2]) return 1;
    if (s == 0) return w || (wr && a[2]);
    if (s == 1 || s == 'h12) return wr;
    if (s == 'h10 || s == 'h11) return 0;
    if (s >= 'h20 && s < 'h28) return 0;
    return 1;
  endfunction

  function automatic logic [63:0] exp_rd(logic [11:0] a, bit w);
    logic [63:0] v;
    int s = int'(a >> 3);
    if (s == 0) return a[2] ? {32'd0, IDENT} : {32'd0, m_ctrl};
    else if (s == 1) v = TYPEV;
    else if (s == 'h10) v = m_cqb;
    else if (s == 'h11) v = m_wptr;
    else if (s == 'h12) v = m_rptr;
    else v = m_tbl[s - 'h20] | tcst(s - 'h20);
    if (w) return v;
    return a[2] ? {32'd0, v[63:32]} : {32'd0, v[31:0]};
  endfunction

  function automatic logic [63:0] mrg(logic [63:0] o, logic [63:0] d, bit w, bit h);
    if (w) return d;
    if (h) return {d[31:0], o[31:0]};
    return {o[63:32], d[31:0]};
  endfunction

  function automatic string tag_of(logic [11:0] a, bit e);
    int s = int'(a >> 3);
    if (e) return "R2";
    if (s == 0) return "R3";
    if (s >= 'h20) return "R7";
    return "R8";
  endfunction

  // drive at negedge, response sampled on the following negedge
  task automatic acc(bit wr, bit w, logic [11:0] a, logic [63:0] d, bit lw, logic [63:0] lv);
    bit e = exp_err(a, w, wr);
    logic [63:0] er = (wr || e) ? 64'd0 : exp_rd(a, w);
    bit was_en = m_ctrl[0];
    bit set_en = wr && !e && a == 0 && d[0] && !was_en;
    bit clr = set_en;
    int s = int'(a >> 3);
    string t = tag_of(a, e);
    req = 1; we = wr; wide = w; addr = a; wd = d; rpw = lw; rpv = lv;
    @(posedge clk);
    if (wr && !e) begin
      if (s == 0) m_ctrl = m_ctrl | d[31:0];
      else if (s == 'h10 && !was_en) begin
        m_cqb = mrg(m_cqb, d, w, a[2]);
        if (w || !a[2]) clr = 1;
      end
      else if (s == 'h11) m_wptr = mrg(m_wptr, d, w, a[2]);
      else if (s >= 'h20 && !was_en) begin
        if (w) m_tbl[s - 'h20] = d & TBL_WMASK;
        else m_tbl[s - 'h20] = mrg(m_tbl[s - 'h20], {32'd0, d[31:0]}, 0, a[2]) & TBL_WMASK;
      end
    end
    if (clr) m_rptr = 0;
    else if (lw) m_rptr = lv;
    @(negedge clk);
    req = 0; rpw = 0;
    chk("R10 valid", {63'd0, rsp_valid}, 64'd1);
    chk({t, " err"}, {63'd0, rsp_err}, {63'd0, e});
    chk({t, " data"}, rdata, er);
    chk("R4 pulse", {63'd0, latch}, {63'd0, set_en});
    chk(clr ? "R6 rptr" : "R9 rptr", rptr, m_rptr);
    chk("R3 en", {63'd0, en}, {63'd0, m_ctrl[0]});
    chk("R5 cqb", cqb, m_cqb);
    for (int k = 0; k < 8; k++) chk("R11 tbl", tbl[64*k +: 64], m_tbl[k] | tcst(k));
  endtask

  function automatic logic [11:0] pick_addr();
    case ($urandom_range(0, 13))
      0: return 12'h000;  1: return 12'h004;  2: return 12'h008;  3: return 12'h00c;
      4: return 12'h080;  5: return 12'h084;  6: return 12'h088;  7: return 12'h08c;
      8: return 12'h090;  9: return 12'h094;
      10, 11: return 12'h100 + 12'($urandom_range(0, 15) * 4);
      12: return 12'($urandom_range(0, 4095) & 12'hffc);
      default: return 12'($urandom_range(0, 4095));
    endcase
  endfunction

  task automatic rnd(int n, bit allow_en);
    for (int i = 0; i < n; i++) begin
      logic [11:0] a = pick_addr();
      logic [63:0] d = {$urandom, $urandom};
      if (a == 0 && !allow_en) d[0] = 0;
      acc($urandom_range(0, 1), $urandom_range(0, 1), a, d,
          $urandom_range(0, 3) == 0, {$urandom, $urandom});
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd20240517));
    m_ctrl = 0; m_cqb = 0; m_wptr = 0; m_rptr = 0;
    for (int k = 0; k < 8; k++) m_tbl[k] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 en", {63'd0, en}, 64'd0);
    chk("R1 latch", {63'd0, latch}, 64'd0);
    chk("R1 rptr", rptr, 64'd0);
    chk("R1 tbl0", tbl[63:0], tcst(0));
    rst_ni = 1;
    @(negedge clk);
    chk("R1 idle", {63'd0, rsp_valid}, 64'd0);

    rnd(400, 0);

    // R6: upper-half base write keeps rptr, lower-half clears it
    acc(0, 0, 12'h004, 0, 1, 64'h55);
    acc(1, 0, 12'h084, 64'h1234, 0, 0);
    chk("R6 upper keeps", rptr, 64'h55);
    acc(1, 0, 12'h080, 64'h5678, 0, 0);
    chk("R6 lower clears", rptr, 64'h0);
    acc(1, 1, 12'h080, 64'hdead_beef_0000_1000, 1, 64'h9);
    chk("R9 clear wins", rptr, 64'h0);
    // R7 masked halves, R11 index
    acc(1, 0, 12'h118, 64'hffff_ffff, 0, 0);
    acc(1, 0, 12'h11c, 64'hffff_ffff, 0, 0);
    acc(0, 1, 12'h118, 0, 0, 0);
    chk("R7 masked", rdata, TBL_WMASK | tcst(3));
    acc(1, 1, 12'h100, '1, 0, 0);
    acc(0, 1, 12'h100, 0, 0, 0);
    chk("R7 wide mask", rdata, TBL_WMASK | tcst(0));
    // R2 corner errors
    acc(0, 1, 12'h000, 0, 0, 0);
    acc(1, 1, 12'h084, 64'h1, 0, 0);
    acc(1, 0, 12'h008, 64'h1, 0, 0);
    acc(1, 0, 12'h094, 64'h1, 0, 0);
    acc(0, 0, 12'h082, 0, 0, 0);
    acc(0, 0, 12'h140, 0, 0, 0);
    // R8 type halves
    acc(0, 0, 12'h00c, 0, 0, 0);
    chk("R8 type hi", rdata, {32'd0, TYPEV[63:32]});
    // R4 enable with nonzero rptr
    acc(0, 0, 12'h004, 0, 1, 64'h77);
    acc(1, 0, 12'h000, 64'h3, 0, 0);
    chk("R4 rptr zero", rptr, 64'h0);
    @(negedge clk);
    chk("R4 pulse once", {63'd0, latch}, 64'd0);
    acc(1, 0, 12'h000, 64'h0, 0, 0);
    chk("R3 still en", {63'd0, en}, 64'd1);
    // R5 locked writes
    keep = cqb;
    acc(1, 0, 12'h080, 64'h1, 0, 0);
    chk("R5 cqb locked", cqb, keep);
    acc(1, 1, 12'h138, '1, 0, 0);
    chk("R5 tbl locked", tbl[7*64 +: 64], m_tbl[7] | tcst(7));
    rnd(400, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule